// File: doc/BRIEF.md
# Scatter-Gather Descriptor Splitter

This block turns a list of memory segments into entries of a physical-region descriptor table. Software or an upstream engine pulses `start` with the number of bytes the transfer needs. The block then accepts segments one at a time, each given as a 64-bit start address and a byte length. It takes from each segment only as many bytes as the transfer still needs. Any piece longer than the per-descriptor limit is cut into consecutive descriptors, and every descriptor goes out through a one-cycle write strobe with its table index.

A run ends when the segment flagged as last has been used up, or when the byte budget reaches zero. It also ends early on an odd segment address or on a full table. At the end the block raises `done` for one cycle, together with a result code and the number of descriptors written. The table depth and the per-descriptor maximum length are parameters, with defaults of 168 entries and 4 MiB.

Top module: `sg_prd_splitter`

## Requirements
- R1: Each accepted segment contributes min(segment length, bytes still requested) bytes, and the remaining request drops by that amount.
- R2: A contribution larger than MAX_CHUNK bytes is written as consecutive descriptors of MAX_CHUNK bytes, with the remainder in the last one. Each descriptor address equals the segment address plus the bytes already covered, carried across all 64 bits.
- R3: A descriptor write presents address bits [31:0] on `desc_addr_lo` and bits [63:32] on `desc_addr_hi`, zero on `desc_rsvd`, and chunk length minus one on `desc_bcnt`. Its `desc_idx` counts up from 0 within a run.
- R4: An accepted segment whose address has bit 0 set ends the run with status 1 (alignment), even when its length is zero. It produces no descriptor.
- R5: When one more descriptor is needed and DEPTH descriptors are already written, the run ends with status 2 (table full) and `desc_count` equal to DEPTH.
- R6: `seg_ready` is high only while the block waits for a segment with a nonzero budget, and it stays low in every cycle that writes a descriptor.
- R7: No segment is accepted after the last-flagged segment or once the budget has reached zero. A request of zero bytes accepts no segment at all.
- R8: A normal end reports status 3 (empty) if no descriptor was written, otherwise status 4 (short) if requested bytes remain, otherwise status 0 (ok). `done` is high for exactly one cycle, and `status` and `desc_count` are valid while it is high.
- R9: After reset `done`, `seg_ready` and `desc_we` are low. A `start` pulse while idle loads the budget and restarts the descriptor count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted while idle) |
| req_bytes | input | 32 | Bytes the transfer needs |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_addr | input | 64 | Segment start address |
| seg_len | input | 32 | Segment length in bytes |
| seg_last | input | 1 | Segment is the last of the list |
| desc_we | output | 1 | Descriptor write strobe |
| desc_idx | output | $clog2(DEPTH) | Table index of the write |
| desc_addr_lo | output | 32 | Descriptor address, low half |
| desc_addr_hi | output | 32 | Descriptor address, high half |
| desc_rsvd | output | 32 | Reserved word, always zero |
| desc_bcnt | output | 32 | Chunk length minus one |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 3 | Result: 0 ok, 1 align, 2 full, 3 empty, 4 short |
| desc_count | output | $clog2(DEPTH+1) | Descriptors written in the run |

## Verification
A wrong budget shows up at the very next segment. Its descriptor lengths are clipped wrongly, or the run ends one segment too early or too late, with a wrong result code. A wrong remaining-length or address register shows up on the next write strobe as a bad `desc_bcnt` or address, and a wrong counter shows up in `desc_idx` of that same write. Because every descriptor is compared as it is written, an internal error becomes visible within one cycle of the write it corrupts. Stale end-state logic only becomes visible on the `done` cycle, through `status` and `desc_count`.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  localparam int SGS_ADDR_W = 64;
  localparam int SGS_LEN_W  = 32;
  localparam int SGS_HALF_W = SGS_ADDR_W / 2;

  typedef enum logic [2:0] {
    SGS_OK    = 3'd0,
    SGS_ALIGN = 3'd1,
    SGS_FULL  = 3'd2,
    SGS_EMPTY = 3'd3,
    SGS_SHORT = 3'd4
  } sgs_status_e;

  function automatic logic [SGS_LEN_W-1:0] sgs_min(input logic [SGS_LEN_W-1:0] a,
                                                   input logic [SGS_LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // result of a run that ended without alignment or capacity fault
  function automatic sgs_status_e sgs_end_code(input logic none_written,
                                               input logic budget_spent);
    if (none_written)       return SGS_EMPTY;
    else if (!budget_spent) return SGS_SHORT;
    else                    return SGS_OK;
  endfunction
endpackage

// File: rtl/sgs_budget.sv
module sgs_budget import sgs_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [SGS_LEN_W-1:0] load_val,
  input  logic                 take,
  input  logic [SGS_LEN_W-1:0] seg_len,
  output logic [SGS_LEN_W-1:0] clip,
  output logic                 budget_zero
);
  logic [SGS_LEN_W-1:0] budget_q;

  always_comb begin
    clip        = sgs_min(seg_len, budget_q);
    budget_zero = (budget_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    budget_q <= '0;
    else if (load) budget_q <= load_val;
    else if (take) budget_q <= budget_q - clip;
  end

  AST_CLIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (clip <= budget_q) && (clip <= seg_len) && !budget_zero); // R1
endmodule

// File: rtl/sgs_chunker.sv
module sgs_chunker import sgs_pkg::*; #(
  parameter int MAX_CHUNK = 4194304
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [SGS_ADDR_W-1:0] load_addr,
  input  logic [SGS_LEN_W-1:0]  load_len,
  input  logic                  step,
  output logic [SGS_ADDR_W-1:0] cur_addr,
  output logic [SGS_LEN_W-1:0]  chunk,
  output logic                  last_chunk
);
  localparam logic [SGS_LEN_W-1:0] MAX_L = SGS_LEN_W'(MAX_CHUNK);

  logic [SGS_LEN_W-1:0] rem_q;

  always_comb begin
    chunk      = sgs_min(rem_q, MAX_L);
    last_chunk = (rem_q <= MAX_L);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      rem_q    <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      rem_q    <= load_len;
    end else if (step) begin
      cur_addr <= cur_addr + SGS_ADDR_W'(chunk);
      rem_q    <= rem_q - chunk;
    end
  end

  AST_CHUNK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (chunk != '0) && (chunk <= MAX_L)); // R2
endmodule

// File: rtl/sg_prd_splitter.sv
module sg_prd_splitter import sgs_pkg::*; #(
  parameter  int MAX_CHUNK = 4194304,
  parameter  int DEPTH     = 168,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SGS_LEN_W-1:0]  req_bytes,
  input  logic                  seg_valid,
  output logic                  seg_ready,
  input  logic [SGS_ADDR_W-1:0] seg_addr,
  input  logic [SGS_LEN_W-1:0]  seg_len,
  input  logic                  seg_last,
  output logic                  desc_we,
  output logic [IDX_W-1:0]      desc_idx,
  output logic [SGS_HALF_W-1:0] desc_addr_lo,
  output logic [SGS_HALF_W-1:0] desc_addr_hi,
  output logic [31:0]           desc_rsvd,
  output logic [SGS_LEN_W-1:0]  desc_bcnt,
  output logic                  done,
  output logic [2:0]            status,
  output logic [CNT_W-1:0]      desc_count
);
  typedef enum logic [1:0] {ST_IDLE, ST_TAKE, ST_EMIT} st_e;

  st_e                   st_q, st_d;
  logic [CNT_W-1:0]      cnt_q;
  logic                  last_q;
  logic                  done_q;
  logic [2:0]            stat_q;

  // named internal events
  logic                  load_ev, hs_ev, odd_ev, take_ev, step_ev, full_w, fin_ev;
  sgs_status_e           fin_code;

  logic [SGS_LEN_W-1:0]  clip, chunk;
  logic                  budget_zero, last_chunk;
  logic [SGS_ADDR_W-1:0] cur_addr;

  sgs_budget u_budget (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .load_val(req_bytes),
    .take(take_ev), .seg_len(seg_len), .clip(clip), .budget_zero(budget_zero)
  );

  sgs_chunker #(.MAX_CHUNK(MAX_CHUNK)) u_chunker (
    .clk(clk), .rst_n(rst_n), .load(take_ev), .load_addr(seg_addr),
    .load_len(clip), .step(step_ev), .cur_addr(cur_addr), .chunk(chunk),
    .last_chunk(last_chunk)
  );

  always_comb begin
    load_ev   = (st_q == ST_IDLE) && start;
    seg_ready = (st_q == ST_TAKE) && !budget_zero;
    hs_ev     = seg_ready && seg_valid;
    odd_ev    = hs_ev && seg_addr[0];
    take_ev   = hs_ev && !seg_addr[0];
    full_w    = (cnt_q == CNT_W'(DEPTH));
    step_ev   = (st_q == ST_EMIT) && !full_w;
    fin_ev    = 1'b0;
    fin_code  = SGS_OK;
    st_d      = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_TAKE;
      ST_TAKE: begin
        if (budget_zero) begin
          fin_ev   = 1'b1;
          fin_code = sgs_end_code(cnt_q == '0, 1'b1);
        end else if (odd_ev) begin
          fin_ev   = 1'b1;
          fin_code = SGS_ALIGN;
        end else if (take_ev) begin
          if (clip != '0) st_d = ST_EMIT;
          else if (seg_last) begin
            fin_ev   = 1'b1;
            fin_code = sgs_end_code(cnt_q == '0, 1'b0);
          end
        end
      end
      ST_EMIT: begin
        if (full_w) begin
          fin_ev   = 1'b1;
          fin_code = SGS_FULL;
        end else if (last_chunk) begin
          if (last_q || budget_zero) begin
            fin_ev   = 1'b1;
            fin_code = sgs_end_code(1'b0, budget_zero);
          end else st_d = ST_TAKE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin_ev) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      stat_q <= 3'd0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_ev;
      if (fin_ev)       stat_q <= fin_code;
      if (load_ev)      cnt_q  <= '0;
      else if (step_ev) cnt_q  <= cnt_q + CNT_W'(1);
      if (take_ev)      last_q <= seg_last;
    end
  end

  always_comb begin
    desc_we      = step_ev;
    desc_idx     = cnt_q[IDX_W-1:0];
    desc_addr_lo = cur_addr[SGS_HALF_W-1:0];
    desc_addr_hi = cur_addr[SGS_ADDR_W-1:SGS_HALF_W];
    desc_rsvd    = '0;
    desc_bcnt    = chunk - SGS_LEN_W'(1);
    done         = done_q;
    status       = stat_q;
    desc_count   = cnt_q;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |-> (desc_count < CNT_W'(DEPTH))); // R5
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd2) |-> (desc_count == CNT_W'(DEPTH))); // R5
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |-> !seg_ready); // R6
  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |-> !desc_addr_lo[0]); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

// File: tb/test_sg_prd_splitter.sv
`timescale 1ns/1ps
module test_sg_prd_splitter;
  localparam int MAXC = 16;
  localparam int DEP  = 4;
  localparam int NV   = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_bytes = '0;
  logic        seg_valid = 1'b0;
  logic        seg_ready;
  logic [63:0] seg_addr = '0;
  logic [31:0] seg_len = '0;
  logic        seg_last = 1'b0;
  logic        desc_we;
  logic [1:0]  desc_idx;
  logic [31:0] desc_addr_lo, desc_addr_hi, desc_rsvd, desc_bcnt;
  logic        done;
  logic [2:0]  status;
  logic [2:0]  desc_count;

  always #2 clk = ~clk;

  sg_prd_splitter #(.MAX_CHUNK(MAXC), .DEPTH(DEP)) i_sg_prd_splitter (
    .clk(clk), .rst_n(rst_n), .start(start), .req_bytes(req_bytes),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .desc_we(desc_we),
    .desc_idx(desc_idx), .desc_addr_lo(desc_addr_lo), .desc_addr_hi(desc_addr_hi),
    .desc_rsvd(desc_rsvd), .desc_bcnt(desc_bcnt), .done(done),
    .status(status), .desc_count(desc_count)
  );

  typedef struct packed {
    logic [31:0] req;
    logic [1:0]  nseg;
    logic [63:0] a0; logic [31:0] l0;
    logic [63:0] a1; logic [31:0] l1;
    logic [63:0] a2; logic [31:0] l2;
    logic [2:0]  est;
    logic [2:0]  ecnt;
  } vec_t;

  // status: 0 ok, 1 align, 2 full, 3 empty, 4 short
  localparam vec_t VECS [0:NV-1] = '{
    '{32'd8,  2'd1, 64'h100, 32'd8,  64'h0, 32'd0, 64'h0, 32'd0, 3'd0, 3'd1},  // R1 single
    '{32'd40, 2'd1, 64'h1000, 32'd40, 64'h0, 32'd0, 64'h0, 32'd0, 3'd0, 3'd3}, // R2 split
    '{32'd20, 2'd2, 64'h200, 32'd10, 64'h300, 32'd30, 64'h0, 32'd0, 3'd0, 3'd2}, // R1 clip
    '{32'd64, 2'd1, 64'h400, 32'd64, 64'h0, 32'd0, 64'h0, 32'd0, 3'd0, 3'd4},  // R5 exact fit
    '{32'd80, 2'd1, 64'h400, 32'd80, 64'h0, 32'd0, 64'h0, 32'd0, 3'd2, 3'd4},  // R5 full
    '{32'd30, 2'd2, 64'h500, 32'd10, 64'h601, 32'd10, 64'h0, 32'd0, 3'd1, 3'd1}, // R4
    '{32'd50, 2'd1, 64'h700, 32'd20, 64'h0, 32'd0, 64'h0, 32'd0, 3'd4, 3'd2},  // R8 short
    '{32'd0,  2'd1, 64'h100, 32'd8,  64'h0, 32'd0, 64'h0, 32'd0, 3'd3, 3'd0},  // R7 zero req
    '{32'd10, 2'd1, 64'h800, 32'd0,  64'h0, 32'd0, 64'h0, 32'd0, 3'd3, 3'd0},  // R8 empty
    '{32'd16, 2'd2, 64'h900, 32'd16, 64'hA00, 32'd16, 64'h0, 32'd0, 3'd0, 3'd1}, // R7 budget out
    '{32'd32, 2'd1, 64'h1_FFFF_FFF8, 32'd32, 64'h0, 32'd0, 64'h0, 32'd0, 3'd0, 3'd2}, // R2 carry
    '{32'd10, 2'd3, 64'h202, 32'd4, 64'h300, 32'd2, 64'h801, 32'd0, 3'd1, 3'd2}  // R4 zero-len odd
  };

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [63:0] exp_a [8];
  logic [31:0] exp_b [8];
  int          exp_n, exp_taken, exp_st;
  int          n_wr, taken;
  bit          got_done;
  logic [2:0]  got_st, got_cnt;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent model of the splitting rules
  task automatic model(input vec_t v);
    logic [63:0] sa [3];
    logic [31:0] sl [3];
    longint budget, take, piece;
    logic [63:0] a;
    bit stop;
    sa[0] = v.a0; sa[1] = v.a1; sa[2] = v.a2;
    sl[0] = v.l0; sl[1] = v.l1; sl[2] = v.l2;
    budget = v.req; exp_n = 0; exp_taken = 0; stop = 0; exp_st = 0;
    for (int s = 0; s < int'(v.nseg); s++) begin
      if (stop || budget == 0) break;
      exp_taken++;
      if (sa[s][0]) begin exp_st = 1; stop = 1; break; end
      take = (sl[s] < budget) ? sl[s] : budget;
      budget -= take;
      a = sa[s];
      while (take > 0) begin
        if (exp_n == DEP) begin exp_st = 2; stop = 1; break; end
        piece = (take > MAXC) ? MAXC : take;
        exp_a[exp_n] = a;
        exp_b[exp_n] = 32'(piece - 1);
        exp_n++;
        a = a + 64'(piece);
        take -= piece;
      end
    end
    if (!stop) exp_st = (exp_n == 0) ? 3 : (budget > 0) ? 4 : 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (desc_we) begin
        if (n_wr < 8)
          chk(desc_addr_lo == exp_a[n_wr][31:0] && desc_addr_hi == exp_a[n_wr][63:32] &&
              desc_bcnt == exp_b[n_wr] && desc_rsvd == 32'd0 && int'(desc_idx) == n_wr,
              "R2/R3 descriptor", {desc_addr_hi, desc_addr_lo}, exp_a[n_wr]);
        else chk(1'b0, "R3 extra write", 64'(n_wr), 64'(exp_n));
        chk(!seg_ready, "R6 ready during write", 64'(seg_ready), 64'd0);
        n_wr++;
      end
      if (done) begin
        got_done = 1'b1;
        got_st   = status;
        got_cnt  = desc_count;
      end
    end
  end

  task automatic run_vec(input vec_t v, input int k);
    logic [63:0] sa [3];
    logic [31:0] sl [3];
    sa[0] = v.a0; sa[1] = v.a1; sa[2] = v.a2;
    sl[0] = v.l0; sl[1] = v.l1; sl[2] = v.l2;
    model(v);
    n_wr = 0; taken = 0; got_done = 1'b0;
    @(negedge clk);
    start = 1'b1; req_bytes = v.req;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < int'(v.nseg); s++) begin
      seg_valid = 1'b1; seg_addr = sa[s]; seg_len = sl[s];
      seg_last = (s == int'(v.nseg) - 1);
      while (!seg_ready && !got_done) @(negedge clk);
      if (got_done) break;
      @(posedge clk);
      taken++;
      @(negedge clk);
    end
    seg_valid = 1'b0; seg_last = 1'b0;
    while (!got_done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(got_st == v.est && int'(got_st) == exp_st, $sformatf("R8 status vec %0d", k),
        64'(got_st), 64'(v.est));
    chk(got_cnt == v.ecnt && int'(got_cnt) == exp_n, $sformatf("R5 count vec %0d", k),
        64'(got_cnt), 64'(v.ecnt));
    chk(n_wr == exp_n, $sformatf("R9 writes vec %0d", k), 64'(n_wr), 64'(exp_n));
    chk(taken == exp_taken, $sformatf("R7 accepted vec %0d", k), 64'(taken), 64'(exp_taken));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !seg_ready && !desc_we, "R9 reset outputs",
        {61'd0, done, seg_ready, desc_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);
    // directed: start again after a full-table run restarts the count (R9)
    run_vec(VECS[4], 100);
    run_vec(VECS[0], 101);
    chk(got_cnt == 3'd1, "R9 count restart", 64'(got_cnt), 64'd1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule